// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches a serial bit stream that arrives one bit per clock and flags every place where the four most recent bits are 1, 1, 0, 1. The oldest of the four comes first. The flag is a Mealy output: it depends on the stored state and on the bit presented in the same cycle. The flag therefore rises in the cycle that carries the completing 1, with no register between the input and the flag.

Matches may overlap. The closing 1 of one match is kept as the leading 1 of the next candidate, so the stream 1101101 yields two flags. A synchronous reset returns the machine to its idle state and discards any partial match.

Internally a package holds the state type and two pure functions, one for the next state and one for the flag. A combinational decode module and a state register module are joined in the top.

Top module: `seq1101_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters its idle state. In the cycle after that edge, `match_out` is 0 even when `bit_in` is 1.
- R2: `match_out` is 1 in a cycle exactly when at least three bits have been taken since the last reset, the three most recent of them are 1, 1, 0 (oldest first), and the current `bit_in` is 1. Otherwise it is 0.
- R3: Overlap is honoured: the input 1101101 raises `match_out` with the 4th bit and again with the 7th bit.
- R4: The flag is combinational. It is high in the same cycle as the completing `bit_in` = 1 and low in the following cycle unless that cycle also completes a match.
- R5: A run of extra leading 1s keeps the machine ready. The input 111101 raises `match_out` only with the 6th bit.
- R6: A 0 that breaks a partial match restarts the search. The input 1001101 raises `match_out` only with the 7th bit.
- R7: A reset in the middle of a partial match discards it. The input 110, then reset, then 1 leaves `match_out` at 0.
- R8: An all-zero stream never raises `match_out`, and after any match the machine stands one 1 into a new candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit for this cycle |
| match_out | output | 1 | High in the cycle whose bit completes 1101 |

## Verification
The bench builds the block with its default parameters: a two-bit binary state code for the four states. With that one build, every state and all eight state-and-input transitions can be reached. The directed streams visit the self-loop on 11, the restart after a broken 110, the overlap back into the one-1 state and a reset taken in the middle of a match. A long pseudo-random stream then compares every cycle against a history-window model that knows nothing of the state graph.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  // Width of the state code; four states need two bits.
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'd0,   // no useful history
    ST_ONE  = 2'd1,   // last bit was 1
    ST_TWO  = 2'd2,   // last two bits were 11
    ST_TAIL = 2'd3    // last three bits were 110
  } det_state_e;

  // Next state for every state and input bit.
  function automatic det_state_e det_next(input det_state_e cur, input logic b);
    det_state_e nxt;
    unique case (cur)
      ST_IDLE: nxt = b ? ST_ONE  : ST_IDLE;
      ST_ONE:  nxt = b ? ST_TWO  : ST_IDLE;
      ST_TWO:  nxt = b ? ST_TWO  : ST_TAIL;
      ST_TAIL: nxt = b ? ST_ONE  : ST_IDLE;  // closing 1 reused as a fresh lead
      default: nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // Mealy flag: only the 1 taken in the 110 state completes the pattern.
  function automatic logic det_flag(input det_state_e cur, input logic b);
    return (cur == ST_TAIL) && b;
  endfunction

endpackage

// File: rtl/seqdet_next_logic.sv
module seqdet_next_logic
  import seqdet_pkg::*;
(
  input  det_state_e cur_state,
  input  logic       bit_in,
  output det_state_e nxt_state,
  output logic       flag
);

  always_comb begin
    nxt_state = det_next(cur_state, bit_in);
    flag      = det_flag(cur_state, bit_in);
  end

endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  det_state_e nxt_state,
  output det_state_e cur_state
);

  always_ff @(posedge clk) begin
    if (rst) cur_state <= ST_IDLE;
    else     cur_state <= nxt_state;
  end

  // R1: a reset edge always lands in idle.
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (cur_state == ST_IDLE))
    else $error("p_reset_idle_r1");

endmodule

// File: rtl/seq1101_detector.sv
module seq1101_detector
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic match_out
);

  det_state_e state_q;
  det_state_e state_d;
  logic       hit;

  seqdet_next_logic u_next (
    .cur_state (state_q),
    .bit_in    (bit_in),
    .nxt_state (state_d),
    .flag      (hit)
  );

  seqdet_state_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (state_d),
    .cur_state (state_q)
  );

  assign match_out = hit;

  // Assertion-side shadow of the raw bit history, kept apart from the state graph.
  logic [2:0] shadow_bits_q;
  logic [1:0] shadow_fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_bits_q <= '0;
      shadow_fill_q <= '0;
    end else begin
      shadow_bits_q <= {shadow_bits_q[1:0], bit_in};
      if (shadow_fill_q != 2'd3) shadow_fill_q <= shadow_fill_q + 2'd1;
    end
  end

  logic window_match;
  assign window_match = (shadow_fill_q == 2'd3) && (shadow_bits_q == 3'b110) && bit_in;

  // R2: the flag agrees with the raw history window in both directions.
  p_flag_window_r2: assert property (@(posedge clk) disable iff (rst) match_out == window_match)
    else $error("p_flag_window_r2");

  // R3/R8: after a match the machine holds exactly one leading 1.
  p_overlap_r3: assert property (@(posedge clk) disable iff (rst) match_out |=> (state_q == ST_ONE))
    else $error("p_overlap_r3");

  // R5: further 1s after 11 keep the machine in the 11 state.
  p_selfloop_r5: assert property (@(posedge clk) disable iff (rst)
      (shadow_fill_q >= 2'd1 && shadow_bits_q[0] && bit_in && state_q != ST_IDLE) |=> (state_q == ST_TWO))
    else $error("p_selfloop_r5");

  // R6: a 0 taken while 110 is held sends the machine back to idle.
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_TAIL && !bit_in) |=> (state_q == ST_IDLE))
    else $error("p_restart_r6");

  // R8: a zero bit can never raise the flag.
  p_zero_quiet_r8: assert property (@(posedge clk) disable iff (rst) !bit_in |-> !match_out)
    else $error("p_zero_quiet_r8");

endmodule

// File: tb/test_seq1101_detector.sv
module test_seq1101_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic match_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Scoreboard queues: expected flag and requirement tag per driven bit.
  bit    q_exp[$];
  string q_tag[$];

  // Independent history model.
  logic [2:0] hist = '0;
  int         fill = 0;

  always #5 clk = ~clk;

  seq1101_detector i_seq1101_detector (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .match_out (match_out)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: present one bit, push the model's expectation, advance the model.
  task automatic drive_bit(input bit x, input string tag);
    @(negedge clk);
    bit_in = x;
    q_exp.push_back((fill >= 3) && (hist == 3'b110) && x);
    q_tag.push_back(tag);
    @(posedge clk);
    hist = {hist[1:0], x};
    if (fill < 3) fill++;
  endtask

  task automatic drive_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) drive_bit(s[i] == "1", tag);
  endtask

  task automatic do_reset(input bit x);
    @(negedge clk);
    rst = 1'b1;
    bit_in = x;
    @(posedge clk);
    hist = '0;
    fill = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compare the flag shortly after each input change.
  always @(negedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      bit e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(match_out, e, t);
    end
  end

  // Count flags explicitly for the directed overlap stream (R3).
  int flag_count = 0;
  always @(negedge clk) begin
    #2;
    if (!rst && match_out) flag_count++;
  end

  initial begin
    // R1: reset state, flag low even with a 1 presented.
    rst = 1'b1;
    bit_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check(match_out, 1'b0, "R1 idle after reset");
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    bit_in = 1'b0;

    // R3 and R4: overlapping stream, two flags in the same cycle as the closing bit.
    flag_count = 0;
    drive_str("1101101", "R3 overlap 1101101");
    drive_bit(1'b0, "R4 flag drops next cycle");
    @(negedge clk);
    #3;
    check(flag_count == 2, 1'b1, "R3 two flags in 1101101");

    // R5: long run of 1s.
    do_reset(1'b0);
    drive_str("111101", "R5 leading ones");

    // R6: broken partial match.
    do_reset(1'b0);
    drive_str("1001101", "R6 restart after 0");

    // R8: zeros only.
    do_reset(1'b0);
    drive_str("00000000", "R8 zero stream");

    // R7: reset mid-match.
    do_reset(1'b0);
    drive_str("110", "R7 before reset");
    do_reset(1'b1);
    drive_bit(1'b1, "R7 after reset no flag");
    drive_str("101", "R7 follow-up");

    // R2: pseudo-random stream against the history model.
    do_reset(1'b0);
    for (int n = 0; n < 400; n++) drive_bit($urandom_range(0, 1) == 1, "R2 random stream");
    drive_str("11011011101", "R2 dense overlaps");

    @(negedge clk);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule